// File: doc/BRIEF.md
# Seekable Memory Port Adapter

This block connects an addressed, byte-wide streaming port to a register target that takes several cycles per access. The streaming side is a seekable memory window. A seek presents an address together with an address-update strobe. Writes arrive as data with a write-enable and are paced by a full flag. Reads return data under an empty flag, and a read-enable consumes it. The target side is a request/acknowledge port with variable latency that carries one access at a time.

The streaming side cannot tell whether a seek comes before a read or before a write. The adapter therefore fetches the addressed location on every seek. It keeps empty high until that fetch returns, and it keeps full high from a write until the target reports that the write is done. One byte is offered per seek. Once the host consumes it, empty stays high until the next seek.

Seeks and writes that arrive while an access is still outstanding are queued. When both are waiting, the write goes to the target before the read.

Top module: `seek_port_adapter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, hostEmpty is 1, hostFull is 0, tgtReq is 0 and hostRdData is 0.
- R2: Every address-update strobe causes one target read (tgtWrite = 0) at the address given with that strobe, whether the host then reads or writes.
- R3: After an address update, hostEmpty stays 1 until the target acknowledges a read for the most recent update. It falls in the cycle after that acknowledge, and hostRdData then equals the data the target returned.
- R4: hostEmpty rises from 0 to 1 only in the cycle after a cycle with hostRdEn = 1. After the byte is consumed, hostEmpty stays 1 until the next address update.
- R5: A write-enable makes hostFull 1 from the next cycle. hostFull returns to 0 in the cycle after the target acknowledges the write, and that write (tgtWrite = 1) carries the captured data.
- R6: tgtReq, tgtAddr, tgtWrite and tgtWrData hold steady from the start of a request until tgtAck, and at most one target access is outstanding.
- R7: An address update that arrives while an access is outstanding is started after that access completes. Data fetched for a superseded update is discarded, and hostEmpty falls only for the newest update.
- R8: A write is sent to the most recently latched address, counting an update in the same cycle. When a write and a read are both waiting, the write is issued first, so a read from the same seek returns the written value.
- R9: hostRdEn while hostEmpty is 1 has no effect: it does not cancel the fetch under way, and hostEmpty still falls when the data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | AW | Seek address |
| hostAddrUpd | input | 1 | Address-update strobe, one cycle per seek |
| hostWrData | input | DW | Write data |
| hostWrEn | input | 1 | Write-enable, one cycle per byte |
| hostFull | output | 1 | Write side busy; the host must not write while it is 1 |
| hostRdData | output | DW | Read data, valid while hostEmpty is 0 |
| hostRdEn | input | 1 | Read-enable, consumes the offered byte |
| hostEmpty | output | 1 | No read data available |
| tgtReq | output | 1 | Target access request, held until acknowledge |
| tgtWrite | output | 1 | 1 for a write access, 0 for a read |
| tgtAddr | output | AW | Target access address |
| tgtWrData | output | DW | Target write data |
| tgtAck | input | 1 | Target completion, one cycle |
| tgtRdData | input | DW | Target read data, valid with tgtAck on a read |

## Verification
The assertions take for granted that the host follows the streaming contract:
- it never pulses write-enable while full is high;
- it seeks only while empty is high, so any offered byte has been consumed first;
- the target raises acknowledge for exactly one cycle and only while a request is pending.

The bench host drains every offered byte before it seeks again and waits for full to drop before its next write. The bench target model counts a programmable latency before it acknowledges, and it drops acknowledge in the following cycle.

// File: rtl/seek_port_pkg.sv
package seek_port_pkg;
  // Strobes from the control unit to the datapath, one cycle each.
  typedef struct packed {
    logic latchAddr;   // take the seek address
    logic captureWr;   // take write data and its address
    logic issue;       // load the target request registers
    logic issueWrite;  // the issued access is a write
    logic captureRd;   // take the target read data
  } ctlStrobes_t;
endpackage

// File: rtl/seek_port_ctrl.sv
module seek_port_ctrl
  import seek_port_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostAddrUpd,
  input  logic        hostWrEn,
  input  logic        hostRdEn,
  input  logic        tgtAck,
  output logic        hostEmpty,
  output logic        hostFull,
  output logic        tgtReq,
  output logic        tgtWrite,
  output ctlStrobes_t strobes
);
  logic pendRd;
  logic pendWr;
  logic ackNow;
  logic idle;
  logic issueWr;
  logic issueRd;

  assign ackNow  = tgtReq & tgtAck;
  assign idle    = ~tgtReq;
  // A waiting write wins over a waiting read.
  assign issueWr = idle & pendWr;
  assign issueRd = idle & ~pendWr & pendRd;

  always_comb begin
    strobes.latchAddr  = hostAddrUpd;
    strobes.captureWr  = hostWrEn;
    strobes.issue      = issueWr | issueRd;
    strobes.issueWrite = issueWr;
    strobes.captureRd  = ackNow & ~tgtWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtReq   <= 1'b0;
      tgtWrite <= 1'b0;
    end else if (issueWr | issueRd) begin
      tgtReq   <= 1'b1;
      tgtWrite <= issueWr;
    end else if (ackNow) begin
      tgtReq   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendRd <= 1'b0;
      pendWr <= 1'b0;
    end else begin
      if (hostAddrUpd)  pendRd <= 1'b1;
      else if (issueRd) pendRd <= 1'b0;
      if (hostWrEn)     pendWr <= 1'b1;
      else if (issueWr) pendWr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostFull <= 1'b0;
    end else if (hostWrEn) begin
      hostFull <= 1'b1;
    end else if (ackNow && tgtWrite) begin
      hostFull <= 1'b0;
    end
  end

  // Empty drops only for data that answers the newest seek, and rises only
  // after the host has consumed that data.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostEmpty <= 1'b1;
    end else if (ackNow && !tgtWrite && !pendRd && !hostAddrUpd) begin
      hostEmpty <= 1'b0;
    end else if (hostRdEn && !hostEmpty) begin
      hostEmpty <= 1'b1;
    end
  end
endmodule

// File: rtl/seek_port_datapath.sv
module seek_port_datapath
  import seek_port_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   strobes,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostWrData,
  input  logic [DW-1:0] tgtRdData,
  output logic [DW-1:0] hostRdData,
  output logic [AW-1:0] tgtAddr,
  output logic [DW-1:0] tgtWrData
);
  logic [AW-1:0] curAddr;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;
  logic [AW-1:0] wrAddrNext;

  // A write uses a seek address that arrives in the same cycle.
  assign wrAddrNext = strobes.latchAddr ? hostAddr : curAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr    <= '0;
      wrAddr     <= '0;
      wrData     <= '0;
      tgtAddr    <= '0;
      tgtWrData  <= '0;
      hostRdData <= '0;
    end else begin
      if (strobes.latchAddr) curAddr <= hostAddr;
      if (strobes.captureWr) begin
        wrAddr <= wrAddrNext;
        wrData <= hostWrData;
      end
      if (strobes.issue) begin
        tgtAddr <= strobes.issueWrite ? wrAddr : curAddr;
        if (strobes.issueWrite) tgtWrData <= wrData;
      end
      if (strobes.captureRd) hostRdData <= tgtRdData;
    end
  end
endmodule

// File: rtl/seek_port_adapter.sv
module seek_port_adapter
  import seek_port_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] hostAddr,
  input  logic          hostAddrUpd,
  input  logic [DW-1:0] hostWrData,
  input  logic          hostWrEn,
  output logic          hostFull,
  output logic [DW-1:0] hostRdData,
  input  logic          hostRdEn,
  output logic          hostEmpty,
  output logic          tgtReq,
  output logic          tgtWrite,
  output logic [AW-1:0] tgtAddr,
  output logic [DW-1:0] tgtWrData,
  input  logic          tgtAck,
  input  logic [DW-1:0] tgtRdData
);
  ctlStrobes_t strobes;

  seek_port_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostAddrUpd(hostAddrUpd),
    .hostWrEn   (hostWrEn),
    .hostRdEn   (hostRdEn),
    .tgtAck     (tgtAck),
    .hostEmpty  (hostEmpty),
    .hostFull   (hostFull),
    .tgtReq     (tgtReq),
    .tgtWrite   (tgtWrite),
    .strobes    (strobes)
  );

  seek_port_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .hostAddr  (hostAddr),
    .hostWrData(hostWrData),
    .tgtRdData (tgtRdData),
    .hostRdData(hostRdData),
    .tgtAddr   (tgtAddr),
    .tgtWrData (tgtWrData)
  );
endmodule

// File: rtl/seek_port_checker.sv
module seek_port_checker #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          hostAddrUpd,
  input logic          hostWrEn,
  input logic          hostFull,
  input logic          hostRdEn,
  input logic          hostEmpty,
  input logic          tgtReq,
  input logic          tgtWrite,
  input logic [AW-1:0] tgtAddr,
  input logic [DW-1:0] tgtWrData,
  input logic          tgtAck
);
  AST_EMPTY_RISE_AFTER_RDEN: assert property (@(posedge clk) disable iff (!rstN)
    (hostEmpty && !$past(hostEmpty)) |-> $past(hostRdEn)); // R4
  AST_EMPTY_FALL_ON_RDACK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostEmpty) |-> $past(tgtReq && tgtAck && !tgtWrite)); // R3
  AST_SEEK_KEEPS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddrUpd && hostEmpty) |=> hostEmpty); // R3
  AST_FULL_AFTER_WREN: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn |=> hostFull); // R5
  AST_FULL_UNTIL_WRACK: assert property (@(posedge clk) disable iff (!rstN)
    (hostFull && !(tgtReq && tgtAck && tgtWrite)) |=> hostFull); // R5
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (tgtReq && !tgtAck) |=> (tgtReq && $stable(tgtAddr) && $stable(tgtWrite)
                             && $stable(tgtWrData))); // R6
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    (tgtReq && tgtAck) |=> !tgtReq); // R6
endmodule

bind seek_port_adapter seek_port_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .hostAddrUpd(hostAddrUpd), .hostWrEn(hostWrEn),
  .hostFull(hostFull), .hostRdEn(hostRdEn), .hostEmpty(hostEmpty),
  .tgtReq(tgtReq), .tgtWrite(tgtWrite), .tgtAddr(tgtAddr),
  .tgtWrData(tgtWrData), .tgtAck(tgtAck)
);

// File: tb/seek_port_adapter_bench.sv
module seek_port_adapter_bench;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NLOC = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] hostAddr = '0;
  logic          hostAddrUpd = 1'b0;
  logic [DW-1:0] hostWrData = '0;
  logic          hostWrEn = 1'b0;
  logic          hostFull;
  logic [DW-1:0] hostRdData;
  logic          hostRdEn = 1'b0;
  logic          hostEmpty;
  logic          tgtReq;
  logic          tgtWrite;
  logic [AW-1:0] tgtAddr;
  logic [DW-1:0] tgtWrData;
  logic          tgtAck = 1'b0;
  logic [DW-1:0] tgtRdData = '0;

  seek_port_adapter #(.AW(AW), .DW(DW)) u_seek_port_adapter (.*);

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  int lat = 0;
  int cnt = 0;
  int rdCount = 0, wrCount = 0;
  int lastRdAckCyc = 0, lastWrAckCyc = 0;
  int reqChanged = 0;
  logic [AW-1:0] lastRdAddr = '0, lastWrAddr = '0, firstAddr = '0;
  logic [DW-1:0] lastWrData = '0;
  logic [DW-1:0] tgtMem [NLOC];
  logic [DW-1:0] expMem [NLOC];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc <= cyc + 1;
  end

  // Target model: acknowledges lat cycles after it first sees a request.
  initial forever begin
    @(negedge clk);
    if (tgtAck) begin
      tgtAck = 1'b0;
      cnt = 0;
    end else if (tgtReq) begin
      if (cnt == 0) firstAddr = tgtAddr;
      else if (tgtAddr != firstAddr) reqChanged++;
      if (cnt >= lat) begin
        tgtAck = 1'b1;
        if (tgtWrite) begin
          tgtMem[tgtAddr] = tgtWrData;
          wrCount++; lastWrAddr = tgtAddr; lastWrData = tgtWrData; lastWrAckCyc = cyc;
        end else begin
          tgtRdData = tgtMem[tgtAddr];
          rdCount++; lastRdAddr = tgtAddr; lastRdAckCyc = cyc;
        end
      end else cnt++;
    end
  end

  task automatic seek(input logic [AW-1:0] a);
    hostAddr = a; hostAddrUpd = 1'b1;
    @(negedge clk); hostAddrUpd = 1'b0;
  endtask

  task automatic writeByte(input logic [DW-1:0] d);
    hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk); hostWrEn = 1'b0;
  endtask

  task automatic waitData(input string tag, input logic [DW-1:0] exp);
    while (hostEmpty) @(negedge clk);
    chk({tag, " data"}, 32'(hostRdData), 32'(exp));
    chk({tag, " empty fall cycle"}, cyc, lastRdAckCyc + 1);
  endtask

  task automatic consume();
    logic [DW-1:0] held;
    held = hostRdData;
    hostRdEn = 1'b1; @(negedge clk); hostRdEn = 1'b0;
    chk("R4 empty set after consume", 32'(hostEmpty), 1);
    hostRdEn = 1'b1; @(negedge clk); hostRdEn = 1'b0;
    @(negedge clk);
    chk("R4 empty stays set until next seek", 32'(hostEmpty), 1);
    chk("R4 read data unchanged", 32'(hostRdData), 32'(held));
  endtask

  task automatic runTests();
    int rdBefore;
    logic [DW-1:0] d;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 empty in reset", 32'(hostEmpty), 1);
    chk("R1 full in reset", 32'(hostFull), 0);
    chk("R1 req in reset", 32'(tgtReq), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 empty after reset", 32'(hostEmpty), 1);
    chk("R1 full after reset", 32'(hostFull), 0);
    chk("R1 rdData after reset", 32'(hostRdData), 0);

    // Seek then write at every address and latency: the seek fetches the old value.
    for (int l = 0; l < 4; l++) begin
      lat = l;
      for (int a = 0; a < NLOC; a++) begin
        d = DW'(a * 7 + l * 29 + 3);
        rdBefore = rdCount;
        seek(AW'(a));
        writeByte(d);
        chk("R5 full after write-enable", 32'(hostFull), 1);
        waitData("R2 seek before write", expMem[a]);
        chk("R2 one read per seek", rdCount, rdBefore + 1);
        chk("R2 read address", 32'(lastRdAddr), a);
        consume();
        while (hostFull) @(negedge clk);
        chk("R8 write address is latched seek", 32'(lastWrAddr), a);
        chk("R5 write data", 32'(lastWrData), 32'(d));
        expMem[a] = d;
      end
    end

    // Plain reads of every location.
    lat = 2;
    for (int a = 0; a < NLOC; a++) begin
      seek(AW'(a));
      waitData("R3 read back", expMem[a]);
      consume();
    end

    // R5 full timing with an idle target.
    lat = 3;
    seek(AW'(5)); waitData("R3 pre-write read", expMem[5]); consume();
    writeByte(8'hC3);
    while (hostFull) @(negedge clk);
    chk("R5 full fall cycle", cyc, lastWrAckCyc + 1);
    expMem[5] = 8'hC3;

    // R8 seek and write in the same cycle: the write is issued first.
    for (int a = 0; a < NLOC; a += 5) begin
      d = DW'(8'h90 + a);
      hostAddr = AW'(a); hostAddrUpd = 1'b1; hostWrData = d; hostWrEn = 1'b1;
      @(negedge clk); hostAddrUpd = 1'b0; hostWrEn = 1'b0;
      waitData("R8 write before read", d);
      chk("R8 write address", 32'(lastWrAddr), a);
      consume();
      expMem[a] = d;
    end

    // R7 a seek during an outstanding read supersedes it.
    lat = 4;
    rdBefore = rdCount;
    seek(AW'(2));
    @(negedge clk); @(negedge clk);
    chk("R7 empty held while outstanding", 32'(hostEmpty), 1);
    seek(AW'(11));
    waitData("R7 newest seek data", expMem[11]);
    chk("R7 both reads issued", rdCount, rdBefore + 2);
    chk("R7 last read address", 32'(lastRdAddr), 11);
    consume();

    // R9 read-enable while empty is high is ignored.
    lat = 3;
    seek(AW'(7));
    hostRdEn = 1'b1; @(negedge clk); hostRdEn = 1'b0;
    chk("R9 empty still high", 32'(hostEmpty), 1);
    waitData("R9 data still delivered", expMem[7]);
    consume();

    chk("R6 request stable until ack", reqChanged, 0);
    chk("R6 target contents", 32'(tgtMem[11]), 32'(expMem[11]));
  endtask

  initial begin
    for (int i = 0; i < NLOC; i++) begin
      tgtMem[i] = DW'(i * 13 + 8'h5A);
      expMem[i] = DW'(i * 13 + 8'h5A);
    end
    fork
      runTests();
      begin
        repeat (150000) @(posedge clk);
        chk("watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule